// File: doc/BRIEF.md
# Indexed Control Register Bank with General-Purpose Pins

This block is a small indexed register file sitting behind a byte-wide host microport. The host presents an 8-bit index together with a write strobe and write data, or with a read strobe. On a read, the selected register value is captured into a read-data register at the clock edge. Three registers are mapped:

- a read-only revision code;
- a direction register for five general-purpose pins;
- a data register that feeds those pins.

Each pin is split into an input level, an output value and an output enable, which pad logic elsewhere combines into a tri-state buffer. Pins whose direction bit is clear are inputs. Their levels are brought into the clock domain through a two-flop synchroniser, and that synchronised level is what the host reads back. The three upper bits of the data register are plain scratch storage. The data register is never cleared by any reset.

There are two ways to restore defaults. An asynchronous active-low reset input does it, and so does any host write to the dedicated reset index, whatever data accompanies that write.

Top module: `gp_regbank`

## Requirements
- R1: While `rst_n` is low, `pin_oe` and `host_rdata` are 0 without waiting for a clock edge, and the direction register reads back 0x00 afterwards.
- R2: A read of index 0x01 returns the revision code, with the major number in bits 7..4 and the minor number in bits 3..0.
- R3: A write to index 0x01 is ignored; later reads still return the revision code.
- R4: A write to index 0x2A stores bits 4..0 as pin directions (1 = output) and drives `pin_oe` from them. Bits 7..5 read back as 0.
- R5: For each pin whose direction bit is 1, `pin_out` carries the matching bit 4..0 of the data register (index 0x2B). Pins configured as inputs have `pin_out` at 0.
- R6: A read of index 0x2B returns the stored bits 7..5 unchanged and, for output pins, the stored bit of that pin.
- R7: For input pins, a read of index 0x2B returns the pin level after two synchroniser stages. A level applied just before a read strobe is not seen on that read; it is seen by a read strobe two cycles later.
- R8: A write of any data to index 0xFF clears the direction register at that clock edge (all pins become inputs) and leaves the data register contents unchanged.
- R9: Indices other than 0x01, 0x2A, 0x2B and 0xFF read as 0x00, and writes to them change no register.
- R10: Write and read strobes are sampled at the rising clock edge, and `host_rdata` holds its value between read strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idx | input | 8 | Register index |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, sampled at the rising edge |
| host_rd | input | 1 | Read strobe, sampled at the rising edge |
| host_rdata | output | 8 | Registered read data |
| pin_in | input | 5 | Pin input levels (asynchronous) |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin output enables, 1 = drive |

## Verification
The bench builds the block with a revision code of major 2 and minor 5, so that a read of index 0x01 returns 0x25. With this value, swapped nibbles or a hard-wired zero show up as a wrong byte. The index parameters and the five-pin width keep their defaults. This lets the bench drive mixed direction patterns, where some pins are outputs and some are inputs, so that every data-read bit is checked against its own source. The synchroniser latency is checked by changing a pin level right before a read strobe and then reading again two cycles later.

// File: rtl/gp_regbank.sv
module gp_regbank #(
  parameter int          IDX_W     = 8,
  parameter int          DATA_W    = 8,
  parameter int          PIN_N     = 5,
  parameter logic [3:0]  REV_MAJOR = 4'h0,
  parameter logic [3:0]  REV_MINOR = 4'h0,
  parameter logic [7:0]  REV_IDX   = 8'h01,
  parameter logic [7:0]  DIR_IDX   = 8'h2A,
  parameter logic [7:0]  DAT_IDX   = 8'h2B,
  parameter logic [7:0]  SRST_IDX  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [PIN_N-1:0]  pin_in,
  output logic [PIN_N-1:0]  pin_out,
  output logic [PIN_N-1:0]  pin_oe
);

  localparam int          PAD_W   = DATA_W - PIN_N;
  localparam logic [7:0]  REV_VAL = {REV_MAJOR, REV_MINOR};

  logic [PIN_N-1:0]  dir_q;
  logic [DATA_W-1:0] dat_q;
  logic [PIN_N-1:0]  sync1_q, sync2_q;
  logic [DATA_W-1:0] rd_val;

  wire wr_dir  = host_wr && (host_idx == IDX_W'(DIR_IDX));
  wire wr_dat  = host_wr && (host_idx == IDX_W'(DAT_IDX));
  wire wr_srst = host_wr && (host_idx == IDX_W'(SRST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= '0;
    else if (wr_srst) dir_q <= '0;
    else if (wr_dir)  dir_q <= host_wdata[PIN_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_dat) dat_q <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    if (host_idx == IDX_W'(REV_IDX))
      rd_val = DATA_W'(REV_VAL);
    else if (host_idx == IDX_W'(DIR_IDX))
      rd_val = {{PAD_W{1'b0}}, dir_q};
    else if (host_idx == IDX_W'(DAT_IDX))
      rd_val = {dat_q[DATA_W-1:PIN_N], (dat_q[PIN_N-1:0] & dir_q) | (sync2_q & ~dir_q)};
    else
      rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_val;
  end

  assign pin_oe  = dir_q;
  assign pin_out = dat_q[PIN_N-1:0] & dir_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && host_rdata == '0));

  // R2
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_idx == IDX_W'(REV_IDX)) |=> host_rdata == DATA_W'(REV_VAL));

  // R3
  rev_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_idx == IDX_W'(REV_IDX)) |=> $stable(pin_oe));

  // R5
  data_to_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_idx == IDX_W'(DAT_IDX)) |=>
      pin_out == ($past(host_wdata[PIN_N-1:0]) & pin_oe));

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_idx == IDX_W'(SRST_IDX)) |=> pin_oe == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/gp_regbank_bench.sv
module gp_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_idx = '0, host_wdata = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic [4:0] pin_in = '0, pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;

  gp_regbank #(.REV_MAJOR(4'h2), .REV_MINOR(4'h5)) u_gp_regbank (
    .clk(clk), .rst_n(rst_n), .host_idx(host_idx), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); host_idx = idx; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk); host_idx = idx; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe in reset", {3'b0, pin_oe}, 8'h00);
    chk("R1 rdata in reset", host_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h2A, v); chk("R1 dir default", v, 8'h00);
  endtask

  task automatic t_rev;
    logic [7:0] v;
    rd(8'h01, v); chk("R2 revision", v, 8'h25);
    wr(8'h01, 8'hAA);
    rd(8'h01, v); chk("R3 revision after write", v, 8'h25);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", host_rdata, 8'h25);
  endtask

  task automatic t_dir;
    logic [7:0] v;
    wr(8'h2A, 8'hFF);
    rd(8'h2A, v); chk("R4 dir readback upper zero", v, 8'h1F);
    chk("R4 oe all out", {3'b0, pin_oe}, 8'h1F);
    wr(8'h2A, 8'h0A);
    chk("R4 oe pattern", {3'b0, pin_oe}, 8'h0A);
  endtask

  task automatic t_out;
    logic [7:0] v;
    wr(8'h2A, 8'h1F);
    pin_in = 5'h09;
    wr(8'h2B, 8'hB6);
    chk("R5 pin_out all out", {3'b0, pin_out}, 8'h16);
    repeat (3) @(negedge clk);
    rd(8'h2B, v); chk("R6 data read all out", v, 8'hB6);
  endtask

  task automatic t_mixed;
    logic [7:0] v;
    pin_in = 5'h1C;
    wr(8'h2A, 8'h03);
    repeat (3) @(negedge clk);
    chk("R5 pin_out mixed", {3'b0, pin_out}, 8'h02);
    rd(8'h2B, v); chk("R6 R7 data read mixed", v, 8'hBE);
    wr(8'h2A, 8'h00);
    pin_in = 5'h0A;
    repeat (3) @(negedge clk);
    rd(8'h2B, v); chk("R7 data read all in", v, 8'hAA);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    pin_in = 5'h15;
    rd(8'h2B, v); chk("R7 not yet visible", v, 8'hAA);
    rd(8'h2B, v);
    rd(8'h2B, v); chk("R7 visible after two stages", v, 8'hB5);
  endtask

  task automatic t_srst;
    logic [7:0] v;
    pin_in = 5'h00;
    wr(8'h2A, 8'h1F);
    wr(8'hFF, 8'h5A);
    chk("R8 oe cleared", {3'b0, pin_oe}, 8'h00);
    rd(8'h2A, v); chk("R8 dir cleared", v, 8'h00);
    wr(8'h2A, 8'h1F);
    rd(8'h2B, v); chk("R8 data kept", v, 8'hB6);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(8'h30, 8'hFF);
    wr(8'h2C, 8'h00);
    chk("R9 oe unchanged", {3'b0, pin_oe}, 8'h1F);
    rd(8'h2B, v); chk("R9 data unchanged", v, 8'hB6);
    rd(8'h30, v); chk("R9 unmapped read", v, 8'h00);
    rd(8'h2C, v); chk("R9 unmapped read 2C", v, 8'h00);
  endtask

  task automatic t_hwreset;
    logic [7:0] v;
    @(negedge clk); #3 rst_n = 1'b0;
    #2;
    chk("R1 async oe clear", {3'b0, pin_oe}, 8'h00);
    chk("R1 async rdata clear", host_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h2A, v); chk("R1 dir after hw reset", v, 8'h00);
  endtask

  initial begin
    #1;
    t_reset();
    t_rev();
    t_dir();
    t_out();
    t_mixed();
    t_sync();
    t_srst();
    t_unmapped();
    t_hwreset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule